// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a memory-mapped bank of general-purpose pins, up to 32 wide, on a simple register bus made of an address, a write strobe, write data and read data. Software sets which pins drive, reads the pins back through a two-flop synchronizer, and changes output bits with separate write-one-to-set and write-one-to-clear registers. This lets independent agents change single bits without a read-modify-write.

Each pin can also act as an interrupt source. Three per-pin configuration registers choose edge or level sensing, positive or negative sense, and single-edge or dual-edge detection. Together they give five modes: rising, falling, both edges, level high and level low. Detected events from enabled pins set a per-pin pending bit. Software acknowledges a pending bit by writing a one to it. The pending bits of enabled pins are ORed into one registered line to a parent interrupt controller. The handler scans the status register to find the sources.

Register word addresses: 0 synchronized pin input (read only), 1 direction, 2 output latch (read only), 3 output set, 4 output clear, 5 interrupt enable (read only), 6 enable set, 7 enable clear, 8 pending status (write one to clear), 9 sense type, 10 sense polarity, 11 dual-edge select. Other addresses read as zero and ignore writes.

Top module: `gpio_irq_bank`

## Requirements
- R1: Address 0 reads the pin inputs after a two-flop synchronizer, so a pin change is visible two clock edges after it is applied.
- R2: The direction register (address 1) holds one bit per pin. A 1 makes that pin drive, and `pinOe` mirrors the register.
- R3: A write to address 3 sets, and a write to address 4 clears, each output bit whose write data bit is 1. Bits written 0 keep their value. `pinOut` and address 2 show the latch.
- R4: A write to address 6 enables, and a write to address 7 disables, the interrupt of each pin whose data bit is 1. Other pins keep their enable. Address 5 reads the enables.
- R5: Address 8 reads the pending bits. Writing a 1 clears that bit, and bits written 0 are left unchanged.
- R6: With sense type 1 (edge), polarity 1 and dual-edge 0, a low-to-high transition of the synchronized pin sets its pending bit.
- R7: With sense type 1, polarity 0 and dual-edge 0, a high-to-low transition sets the pending bit.
- R8: With sense type 1 and dual-edge 1, either transition sets the pending bit, whatever the polarity.
- R9: With sense type 0 (level), the pending bit is set in every cycle that the pin is at its active level (high for polarity 1, low for polarity 0). An acknowledge during the active level leaves the bit set.
- R10: A pin whose interrupt is disabled never sets its pending bit. Bits that are already pending stay pending until they are acknowledged.
- R11: `irqOut` is high exactly one cycle after any pin is both pending and enabled, and stays low otherwise.
- R12: When a pin's event and an acknowledge of that pin fall in the same cycle, the pending bit stays set.
- R13: Reset clears direction, output latch, enables, configuration, pending bits and `irqOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 4 | Register word address |
| busWe | input | 1 | Write strobe |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for `busAddr`, combinational |
| pinIn | input | NUM_PINS | Asynchronous pin inputs |
| pinOut | output | NUM_PINS | Output latch values |
| pinOe | output | NUM_PINS | Per-pin drive enable |
| irqOut | output | 1 | Combined interrupt to the parent controller |

## Verification
The hardest situation to reach is an acknowledge write landing in the exact cycle that a new edge is detected on the same pin. Detection lags the pin by the synchronizer and the history flop. The bench first makes a dual-edge pin pending. It then drives the opposite transition and starts the acknowledge write so that the write's clock edge is the one where the edge is seen, and it checks that the bit survives. The same timing count is used to show that a level-sensed pin stays pending through an acknowledge, and that a pending but disabled pin keeps the combined line low.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int REG_ADDR_W = 4;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_PIN    = 4'd0,
    REG_DIR    = 4'd1,
    REG_OUT    = 4'd2,
    REG_OUTSET = 4'd3,
    REG_OUTCLR = 4'd4,
    REG_IEN    = 4'd5,
    REG_IENSET = 4'd6,
    REG_IENCLR = 4'd7,
    REG_STAT   = 4'd8,
    REG_TRIG   = 4'd9,
    REG_POL    = 4'd10,
    REG_BOTH   = 4'd11
  } regIdx_e;

  // write strobes and read select from control to datapath
  typedef struct packed {
    logic    dir;
    logic    outSet;
    logic    outClr;
    logic    ienSet;
    logic    ienClr;
    logic    ack;
    logic    trig;
    logic    pol;
    logic    both;
    regIdx_e rdSel;
  } strobes_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic                  busWe,
  output strobes_t              stb
);

  always_comb begin
    stb       = '0;
    stb.rdSel = regIdx_e'(busAddr);
    if (busWe) begin
      case (busAddr)
        REG_DIR:    stb.dir    = 1'b1;
        REG_OUTSET: stb.outSet = 1'b1;
        REG_OUTCLR: stb.outClr = 1'b1;
        REG_IENSET: stb.ienSet = 1'b1;
        REG_IENCLR: stb.ienClr = 1'b1;
        REG_STAT:   stb.ack    = 1'b1;
        REG_TRIG:   stb.trig   = 1'b1;
        REG_POL:    stb.pol    = 1'b1;
        REG_BOTH:   stb.both   = 1'b1;
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            stb,
  input  logic [DATA_W-1:0]   wData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [DATA_W-1:0]   rData,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] pendVec,
  output logic [NUM_PINS-1:0] ienVec,
  output logic [NUM_PINS-1:0] hitVec,
  output logic                irqOut
);

  logic [NUM_PINS-1:0] wBits;
  logic [NUM_PINS-1:0] meta, syncQ, prevQ;
  logic [NUM_PINS-1:0] dirQ, outQ, ienQ, pendQ;
  logic [NUM_PINS-1:0] trigQ, polQ, bothQ;
  logic [NUM_PINS-1:0] ackMask;
  logic                irqQ;

  assign wBits   = wData[NUM_PINS-1:0];
  assign ackMask = stb.ack ? wBits : '0;

  // input synchronizer and one-cycle history for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta  <= '0;
      syncQ <= '0;
      prevQ <= '0;
    end else begin
      meta  <= pinIn;
      syncQ <= meta;
      prevQ <= syncQ;
    end
  end

  // software-visible configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ  <= '0;
      outQ  <= '0;
      ienQ  <= '0;
      trigQ <= '0;
      polQ  <= '0;
      bothQ <= '0;
    end else begin
      if (stb.dir)    dirQ  <= wBits;
      if (stb.trig)   trigQ <= wBits;
      if (stb.pol)    polQ  <= wBits;
      if (stb.both)   bothQ <= wBits;
      if (stb.outSet) outQ  <= outQ | wBits;
      if (stb.outClr) outQ  <= outQ & ~wBits;
      if (stb.ienSet) ienQ  <= ienQ | wBits;
      if (stb.ienClr) ienQ  <= ienQ & ~wBits;
    end
  end

  // per-pin event detection
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic rise, fall, edgeHit, levelHit;
    assign rise     = syncQ[p] & ~prevQ[p];
    assign fall     = ~syncQ[p] & prevQ[p];
    assign edgeHit  = bothQ[p] ? (rise | fall) : (polQ[p] ? rise : fall);
    assign levelHit = polQ[p] ? syncQ[p] : ~syncQ[p];
    assign hitVec[p] = ienQ[p] & (trigQ[p] ? edgeHit : levelHit);
  end

  // pending: a new event outranks an acknowledge in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      irqQ  <= 1'b0;
    end else begin
      pendQ <= (pendQ & ~ackMask) | hitVec;
      irqQ  <= |(pendQ & ienQ);
    end
  end

  always_comb begin
    rData = '0;
    case (stb.rdSel)
      REG_PIN:  rData[NUM_PINS-1:0] = syncQ;
      REG_DIR:  rData[NUM_PINS-1:0] = dirQ;
      REG_OUT:  rData[NUM_PINS-1:0] = outQ;
      REG_IEN:  rData[NUM_PINS-1:0] = ienQ;
      REG_STAT: rData[NUM_PINS-1:0] = pendQ;
      REG_TRIG: rData[NUM_PINS-1:0] = trigQ;
      REG_POL:  rData[NUM_PINS-1:0] = polQ;
      REG_BOTH: rData[NUM_PINS-1:0] = bothQ;
      default:  rData = '0;
    endcase
  end

  assign pinOut  = outQ;
  assign pinOe   = dirQ;
  assign pendVec = pendQ;
  assign ienVec  = ienQ;
  assign irqOut  = irqQ;

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic                  busWe,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [NUM_PINS-1:0]   pinOut,
  output logic [NUM_PINS-1:0]   pinOe,
  output logic                  irqOut
);

  strobes_t            stb;
  logic [NUM_PINS-1:0] pendVec, ienVec, hitVec;

  gpio_irq_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .stb     (stb)
  );

  gpio_irq_datapath #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wData   (busWdata),
    .pinIn   (pinIn),
    .rData   (busRdata),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .pendVec (pendVec),
    .ienVec  (ienVec),
    .hitVec  (hitVec),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [REG_ADDR_W-1:0] busAddr,
  input logic                  busWe,
  input logic [DATA_W-1:0]     busWdata,
  input logic [NUM_PINS-1:0]   pinOut,
  input logic                  irqOut,
  input logic [NUM_PINS-1:0]   pendVec,
  input logic [NUM_PINS-1:0]   ienVec,
  input logic [NUM_PINS-1:0]   hitVec
);

  logic [NUM_PINS-1:0] wb;
  assign wb = busWdata[NUM_PINS-1:0];

  a_r3_out_set: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == REG_OUTSET) |=> ((pinOut & $past(wb)) == $past(wb)));

  a_r3_out_clr: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == REG_OUTCLR) |=> ((pinOut & $past(wb)) == '0));

  a_r4_ien_set: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == REG_IENSET) |=> ((ienVec & $past(wb)) == $past(wb)));

  a_r4_ien_clr: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == REG_IENCLR) |=> ((ienVec & $past(wb)) == '0));

  a_r5_ack_all: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == REG_STAT && (&busWdata) && hitVec == '0) |=> (pendVec == '0));

  a_r12_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    (hitVec != '0) |=> ((pendVec & $past(hitVec)) == $past(hitVec)));

  a_r10_disabled_no_event: assert property (@(posedge clk) disable iff (!rstN)
    ((hitVec & ~ienVec) == '0));

  a_r11_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past((pendVec & ienVec) != '0));

  a_r13_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(rstN)) |-> !irqOut);

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
  .NUM_PINS (NUM_PINS),
  .DATA_W   (DATA_W)
) u_chk (.*);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;

  localparam int NUM_PINS = 32;
  localparam int DATA_W   = 32;

  localparam logic [2:0] OP_WR   = 3'd0;
  localparam logic [2:0] OP_RD   = 3'd1;
  localparam logic [2:0] OP_PIN  = 3'd2;
  localparam logic [2:0] OP_WAIT = 3'd3;
  localparam logic [2:0] OP_IRQ  = 3'd4;
  localparam logic [2:0] OP_OUT  = 3'd5;
  localparam logic [2:0] OP_OE   = 3'd6;

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 62;
  localparam vec_t VECS [NV] = '{
    '{OP_WR,   4'd1,  32'h0000_00F0, 4'd2},  // R2 direction
    '{OP_OE,   4'd0,  32'h0000_00F0, 4'd2},
    '{OP_RD,   4'd1,  32'h0000_00F0, 4'd2},
    '{OP_WR,   4'd3,  32'h0000_00A5, 4'd3},  // R3 set
    '{OP_WR,   4'd3,  32'h0000_0000, 4'd3},  // R3 zero bits no effect
    '{OP_OUT,  4'd0,  32'h0000_00A5, 4'd3},
    '{OP_WR,   4'd4,  32'h0000_0005, 4'd3},  // R3 clear
    '{OP_OUT,  4'd0,  32'h0000_00A0, 4'd3},
    '{OP_RD,   4'd2,  32'h0000_00A0, 4'd3},
    '{OP_PIN,  4'd0,  32'h1234_5678, 4'd1},  // R1 synchronized input
    '{OP_WAIT, 4'd0,  32'd2,         4'd1},
    '{OP_RD,   4'd0,  32'h1234_5678, 4'd1},
    '{OP_RD,   4'd8,  32'h0000_0000, 4'd10}, // R10 nothing enabled
    '{OP_PIN,  4'd0,  32'h0000_0000, 4'd1},
    '{OP_WAIT, 4'd0,  32'd3,         4'd1},
    '{OP_WR,   4'd9,  32'h0000_0007, 4'd6},  // R6 R7 R8 edge pins 0..2
    '{OP_WR,   4'd10, 32'h0000_0009, 4'd6},
    '{OP_WR,   4'd11, 32'h0000_0004, 4'd8},
    '{OP_WR,   4'd6,  32'h0000_000F, 4'd4},  // R4 enable set
    '{OP_RD,   4'd5,  32'h0000_000F, 4'd4},
    '{OP_WAIT, 4'd0,  32'd3,         4'd9},
    '{OP_RD,   4'd8,  32'h0000_0000, 4'd9},  // R9 level high pin idle low
    '{OP_PIN,  4'd0,  32'h0000_0007, 4'd6},
    '{OP_WAIT, 4'd0,  32'd3,         4'd6},
    '{OP_RD,   4'd8,  32'h0000_0005, 4'd6},  // R6 rise pin0, R8 pin2
    '{OP_IRQ,  4'd0,  32'h0000_0001, 4'd11}, // R11
    '{OP_WR,   4'd8,  32'h0000_0005, 4'd5},  // R5 ack
    '{OP_RD,   4'd8,  32'h0000_0000, 4'd5},
    '{OP_IRQ,  4'd0,  32'h0000_0000, 4'd11},
    '{OP_PIN,  4'd0,  32'h0000_0000, 4'd7},
    '{OP_WAIT, 4'd0,  32'd3,         4'd7},
    '{OP_RD,   4'd8,  32'h0000_0006, 4'd7},  // R7 fall pin1, R8 pin2
    '{OP_WR,   4'd8,  32'hFFFF_FFF9, 4'd5},  // R5 zero bits keep
    '{OP_RD,   4'd8,  32'h0000_0006, 4'd5},
    '{OP_WR,   4'd8,  32'h0000_0006, 4'd5},
    '{OP_RD,   4'd8,  32'h0000_0000, 4'd5},
    '{OP_PIN,  4'd0,  32'h0000_0008, 4'd9},
    '{OP_WAIT, 4'd0,  32'd3,         4'd9},
    '{OP_RD,   4'd8,  32'h0000_0008, 4'd9},  // R9 level high
    '{OP_WR,   4'd8,  32'h0000_0008, 4'd9},
    '{OP_RD,   4'd8,  32'h0000_0008, 4'd9},  // R9 reasserts
    '{OP_PIN,  4'd0,  32'h0000_0000, 4'd9},
    '{OP_WAIT, 4'd0,  32'd3,         4'd9},
    '{OP_WR,   4'd8,  32'h0000_0008, 4'd9},
    '{OP_RD,   4'd8,  32'h0000_0000, 4'd9},
    '{OP_WR,   4'd6,  32'h0000_0010, 4'd4},
    '{OP_WAIT, 4'd0,  32'd2,         4'd9},
    '{OP_RD,   4'd8,  32'h0000_0010, 4'd9},  // R9 level low
    '{OP_RD,   4'd5,  32'h0000_001F, 4'd4},  // R4 others kept
    '{OP_WR,   4'd7,  32'h0000_0010, 4'd4},
    '{OP_RD,   4'd5,  32'h0000_000F, 4'd4},  // R4 clear
    '{OP_WR,   4'd8,  32'h0000_0010, 4'd10},
    '{OP_RD,   4'd8,  32'h0000_0000, 4'd10}, // R10 disabled stays clear
    '{OP_PIN,  4'd0,  32'h0000_0001, 4'd11},
    '{OP_WAIT, 4'd0,  32'd3,         4'd11},
    '{OP_WR,   4'd7,  32'h0000_0001, 4'd11},
    '{OP_WAIT, 4'd0,  32'd1,         4'd11},
    '{OP_RD,   4'd8,  32'h0000_0001, 4'd11}, // R11 pending kept
    '{OP_IRQ,  4'd0,  32'h0000_0000, 4'd11}, // R11 masked line low
    '{OP_WR,   4'd8,  32'h0000_0001, 4'd5},
    '{OP_WR,   4'd6,  32'h0000_0001, 4'd4},
    '{OP_RD,   4'd8,  32'h0000_0000, 4'd5}
  };

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [3:0]          busAddr = '0;
  logic                busWe = 1'b0;
  logic [DATA_W-1:0]   busWdata = '0;
  logic [DATA_W-1:0]   busRdata;
  logic [NUM_PINS-1:0] pinIn = '0;
  logic [NUM_PINS-1:0] pinOut;
  logic [NUM_PINS-1:0] pinOe;
  logic                irqOut;

  int checkCount = 0;
  int failCount  = 0;

  always #10 clk = ~clk;

  gpio_irq_bank #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [3:0] a, input int req, input logic [31:0] exp);
    @(negedge clk);
    busAddr = a; busWe = 1'b0;
    #1 check(req, busRdata, exp);
  endtask

  task automatic setPins(input logic [31:0] v);
    @(negedge clk);
    pinIn = v;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkReset();
    #1;
    check(13, {31'b0, irqOut}, 32'h0);   // R13
    check(13, pinOut, 32'h0);            // R13
    check(13, pinOe, 32'h0);             // R13
    busRead(4'd8, 13, 32'h0);            // R13 pending
    busRead(4'd5, 13, 32'h0);            // R13 enables
    busRead(4'd9, 13, 32'h0);            // R13 sense type
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkReset();

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      case (v.op)
        OP_WR:   busWrite(v.addr, v.data);
        OP_RD:   busRead(v.addr, int'(v.req), v.data);
        OP_PIN:  setPins(v.data);
        OP_WAIT: waitCycles(int'(v.data));
        OP_IRQ:  begin @(negedge clk); #1 check(int'(v.req), {31'b0, irqOut}, v.data); end
        OP_OUT:  begin @(negedge clk); #1 check(int'(v.req), pinOut, v.data); end
        OP_OE:   begin @(negedge clk); #1 check(int'(v.req), pinOe, v.data); end
        default: ;
      endcase
    end

    // R12: acknowledge lands on the clock edge where a new edge is seen
    setPins(32'h0000_0005);              // pin2 rises
    waitCycles(3);
    busRead(4'd8, 8, 32'h0000_0004);     // R8
    setPins(32'h0000_0001);              // pin2 falls
    waitCycles(1);
    busWrite(4'd8, 32'h0000_0004);       // write edge = detection edge
    busRead(4'd8, 12, 32'h0000_0004);    // R12 event wins
    busWrite(4'd8, 32'h0000_0004);
    busRead(4'd8, 12, 32'h0000_0000);    // R12 plain ack clears

    // R13: reset in mid-run with configuration present
    busWrite(4'd1, 32'h0000_FFFF);
    busWrite(4'd3, 32'h0000_00FF);
    @(negedge clk);
    rstN = 1'b0;
    waitCycles(2);
    rstN = 1'b1;
    checkReset();
    busRead(4'd2, 13, 32'h0);            // R13 output latch

    $display("  End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule